// File: doc/BRIEF.md
# Cross-Core Breakpoint Manager

This block spreads a breakpoint halt across the cores of a four-core debug system. Each core's breakpoint comparator sends a one-cycle hit pulse. For every core the block raises a debug-exception request that pulls that core into its monitoring exception. The request stays asserted until the core acknowledges it. The core can then run its debug service routine and later resume.

Two small configuration registers decide which cores follow a hit on another core. Each register holds one bit per core. A "join" register marks the cores that are related to the others. A "mask" register can exclude a core from being pulled in, even when it is marked as related. A core's own hit always raises its own request.

The registers are written from the debug (JTAG-side) logic over a plain synchronous write port in the system clock domain. The reset input is asynchronous and active low. Its release is synchronised to the system clock inside the block.

Top module: `xcore_halt_mgr`

## Requirements
- R1: While reset is asserted, and after it is released with no hit input seen yet, all request outputs are 0 and both configuration registers are 0.
- R2: A hit on core k sets req_o[k] on the next clock edge, whatever the configuration bits of core k are.
- R3: With the configuration as it is after reset, a hit on one core raises the request of that core only.
- R4: A hit on any core j other than k sets req_o[k] on the next edge when join bit k is 1 and mask bit k is 0.
- R5: When mask bit k is 1, a hit on other cores never sets req_o[k].
- R6: When join bit k is 0, a hit on other cores never sets req_o[k].
- R7: Once set, req_o[k] stays 1 until ack_i[k] is 1 at a clock edge. It is 0 after that edge unless a new trigger for core k arrives in the same cycle.
- R8: If a trigger for core k and ack_i[k] arrive in the same cycle, req_o[k] is 1 after that edge, so that no breakpoint is lost.
- R9: A write with cfg_we_i=1 loads cfg_wdata_i into the join register at address 0 and into the mask register at address 1. Bit k belongs to core k. Writes to addresses 2 and 3 change neither register. A new value takes effect for hits from the cycle after the write.
- R10: While cfg_we_i is 0, the address and data inputs have no effect on either register.
- R11: Hits on several cores in the same cycle are combined. Each core's request is the OR of its own hit and its pull-in from every other hitting core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address: 0 join, 1 mask, 2 and 3 unused |
| cfg_wdata_i | input | 4 | Configuration write data, bit k for core k |
| hit_i | input | 4 | Breakpoint-hit pulse per core from its comparator |
| ack_i | input | 4 | Exception acknowledge per core |
| req_o | output | 4 | Debug-exception request per core, held until acknowledged |

## Verification
The bench builds the block with its defaults: four cores and a two-stage reset synchroniser. With four cores, every core can be pulled in by a hit on any of the three others. Single hits, simultaneous hits, hits on masked cores and hits on unrelated cores can therefore all be mixed in one sequence. This lets the bench reach joined cores, masked cores and unrelated cores at the same time. It also covers the case where a new trigger and an acknowledge meet in the same cycle, and configuration writes to the two unused addresses.

// File: rtl/xhm_pkg.sv
package xhm_pkg;
  localparam int unsigned CFG_ADDR_W = 2;

  typedef enum logic [CFG_ADDR_W-1:0] {
    CFG_JOIN = 2'd0,
    CFG_MASK = 2'd1
  } cfg_sel_e;
endpackage

// File: rtl/xhm_rst_sync.sv
module xhm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/xhm_cfg_regs.sv
module xhm_cfg_regs
  import xhm_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_ADDR_W-1:0] addr_i,
  input  logic [NUM_CORES-1:0]  wdata_i,
  output logic [NUM_CORES-1:0]  join_o,
  output logic [NUM_CORES-1:0]  mask_o
);
  logic [NUM_CORES-1:0] join_q, join_d;
  logic [NUM_CORES-1:0] mask_q, mask_d;
  logic                 join_en, mask_en;

  always_comb begin
    join_en = we_i && (addr_i == CFG_JOIN);
    mask_en = we_i && (addr_i == CFG_MASK);
    join_d  = join_en ? wdata_i : join_q;
    mask_d  = mask_en ? wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      join_q <= '0;
      mask_q <= '0;
    end else begin
      join_q <= join_d;
      mask_q <= mask_d;
    end
  end

  assign join_o = join_q;
  assign mask_o = mask_q;

  // R10: no strobe, no change
  a_r10_idle_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(join_q) && $stable(mask_q)));

  // R9: unused addresses leave both registers alone
  a_r9_unused_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[1]) |=> ($stable(join_q) && $stable(mask_q)));
endmodule

// File: rtl/xhm_fanout.sv
module xhm_fanout #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] hit_i,
  input  logic [NUM_CORES-1:0] join_i,
  input  logic [NUM_CORES-1:0] mask_i,
  output logic [NUM_CORES-1:0] trig_o
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    localparam logic [NUM_CORES-1:0] SELF = NUM_CORES'(1) << k;
    logic others_hit;
    logic pulled_in;

    always_comb begin
      others_hit = |(hit_i & ~SELF);
      pulled_in  = others_hit && join_i[k] && !mask_i[k];
      trig_o[k]  = hit_i[k] || pulled_in;
    end

    // R2: own hit always triggers the core
    always_comb begin
      a_r2_own_trig: assert (!hit_i[k] || trig_o[k]);
    end
  end
endmodule

// File: rtl/xhm_req_hold.sv
module xhm_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q, req_d;

  always_comb begin
    req_d = trig_i || (req_q && !ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  // R7: held while not acknowledged
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);

  // R7: cleared after acknowledge without new trigger
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !trig_i) |=> !req_q);

  // R8: a trigger wins over a simultaneous acknowledge
  a_r8_trig_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> req_q);
endmodule

// File: rtl/xcore_halt_mgr.sv
module xcore_halt_mgr
  import xhm_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_CORES-1:0]  cfg_wdata_i,
  input  logic [NUM_CORES-1:0]  hit_i,
  input  logic [NUM_CORES-1:0]  ack_i,
  output logic [NUM_CORES-1:0]  req_o
);
  logic                 rst_n_s;
  logic [NUM_CORES-1:0] join_q;
  logic [NUM_CORES-1:0] mask_q;
  logic [NUM_CORES-1:0] trig;

  xhm_rst_sync #(.STAGES(SYNC_DEPTH)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  xhm_cfg_regs #(.NUM_CORES(NUM_CORES)) i_cfg_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .join_o  (join_q),
    .mask_o  (mask_q)
  );

  xhm_fanout #(.NUM_CORES(NUM_CORES)) i_fanout (
    .hit_i  (hit_i),
    .join_i (join_q),
    .mask_i (mask_q),
    .trig_o (trig)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_hold
    localparam logic [NUM_CORES-1:0] SELF = NUM_CORES'(1) << k;

    xhm_req_hold i_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_n_s),
      .trig_i (trig[k]),
      .ack_i  (ack_i[k]),
      .req_o  (req_o[k])
    );

    // R2: own hit reaches the output one edge later
    a_r2_own_hit: assert property (@(posedge clk_i) disable iff (!rst_n_s)
      hit_i[k] |=> req_o[k]);

    // R4: joined and unmasked core follows another core's hit
    a_r4_pull_in: assert property (@(posedge clk_i) disable iff (!rst_n_s)
      ((|(hit_i & ~SELF)) && join_q[k] && !mask_q[k]) |=> req_o[k]);

    // R5: masked idle core stays idle without its own hit
    a_r5_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_n_s)
      (!hit_i[k] && mask_q[k] && !req_o[k]) |=> !req_o[k]);

    // R6: unrelated idle core stays idle without its own hit
    a_r6_unjoined_idle: assert property (@(posedge clk_i) disable iff (!rst_n_s)
      (!hit_i[k] && !join_q[k] && !req_o[k]) |=> !req_o[k]);
  end

  // R1: nothing requested while in reset
  always_comb begin
    a_r1_reset_quiet: assert (rst_n_s || (req_o == '0));
  end
endmodule

// File: tb/test_xcore_halt_mgr.sv
module test_xcore_halt_mgr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [1:0] addr;
  logic [3:0] wdata;
  logic [3:0] hit;
  logic [3:0] ack;
  logic [3:0] req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  logic [3:0] m_join = '0;
  logic [3:0] m_mask = '0;
  logic [3:0] m_req  = '0;

  always #2 clk = ~clk;

  xcore_halt_mgr i_xcore_halt_mgr (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .hit_i       (hit),
    .ack_i       (ack),
    .req_o       (req)
  );

  task automatic cyc(input logic w, input logic [1:0] a, input logic [3:0] d,
                     input logic [3:0] h, input logic [3:0] k, input string tag);
    logic [3:0] trig;
    @(negedge clk);
    we = w; addr = a; wdata = d; hit = h; ack = k;
    for (int c = 0; c < 4; c++) begin
      logic oth;
      oth = |(h & ~(4'b0001 << c));
      trig[c] = h[c] | (oth & m_join[c] & ~m_mask[c]);
    end
    m_req = trig | (m_req & ~k);
    if (w && a == 2'd0) m_join = d;
    if (w && a == 2'd1) m_mask = d;
    exp_q.push_back(m_req);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'h0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d, input string tag);
    cyc(1'b1, a, d, 4'h0, 4'h0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (req !== e) begin
        errors++;
        $display("FAIL %s req actual=%b expected=%b", t, req, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; hit = '0; ack = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (req !== 4'h0) begin
      errors++;
      $display("FAIL R1 in reset actual=%b expected=0000", req);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (req !== 4'h0) begin
      errors++;
      $display("FAIL R1 after reset actual=%b expected=0000", req);
    end
    // R3: default configuration isolates the cores
    cyc(1'b0, 2'd0, 4'h0, 4'b0010, 4'h0, "R3 single core halt");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b0010, "R7 ack clears");
    // R9 / R4: all joined, none masked
    wr(2'd0, 4'b1111, "R9 write join");
    wr(2'd1, 4'b0000, "R9 write mask");
    cyc(1'b0, 2'd0, 4'h0, 4'b0001, 4'h0, "R4 pull in all");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    // R5: mask core 2
    wr(2'd1, 4'b0100, "R9 write mask");
    cyc(1'b0, 2'd0, 4'h0, 4'b1000, 4'h0, "R5 masked core stays");
    cyc(1'b0, 2'd0, 4'h0, 4'b0100, 4'h0, "R2 masked own hit");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    // R6: core 3 not joined
    wr(2'd0, 4'b0011, "R9 write join");
    cyc(1'b0, 2'd0, 4'h0, 4'b0100, 4'h0, "R6 unjoined stays");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    // R9: unused addresses ignored
    wr(2'd2, 4'b0000, "R9 addr2 ignored");
    wr(2'd3, 4'b1111, "R9 addr3 ignored");
    cyc(1'b0, 2'd0, 4'h0, 4'b1000, 4'h0, "R9 cfg intact");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    // R10: data without strobe ignored
    cyc(1'b0, 2'd0, 4'b1100, 4'h0, 4'h0, "R10 no strobe join");
    cyc(1'b0, 2'd1, 4'b0011, 4'h0, 4'h0, "R10 no strobe mask");
    cyc(1'b0, 2'd0, 4'h0, 4'b0010, 4'h0, "R10 cfg intact");
    // R7: hold without ack, partial ack
    idle("R7 hold 1");
    idle("R7 hold 2");
    idle("R7 hold 3");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b0001, "R7 partial ack");
    idle("R7 hold rest");
    // R8: trigger meets ack on core 1
    cyc(1'b0, 2'd0, 4'h0, 4'b0010, 4'b0010, "R8 trigger wins");
    cyc(1'b0, 2'd0, 4'h0, 4'b0001, 4'b0011, "R8 pull-in wins");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    // R11: simultaneous hits
    wr(2'd0, 4'b0000, "R9 write join");
    cyc(1'b0, 2'd0, 4'h0, 4'b0101, 4'h0, "R11 two isolated hits");
    cyc(1'b0, 2'd0, 4'h0, 4'h0, 4'b1111, "R7 ack all");
    wr(2'd0, 4'b1010, "R9 write join");
    wr(2'd1, 4'b0010, "R9 write mask");
    cyc(1'b0, 2'd0, 4'h0, 4'b0101, 4'h0, "R11 combined hits");
    cyc(1'b0, 2'd0, 4'h0, 4'b1000, 4'b1111, "R11 hit with ack");
    idle("R11 settle");
    idle("R11 settle");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule